// File: doc/BRIEF.md
# Serial Conversion Result Shifter

This block is the output port of a sampling converter. A host reads each 12-bit result by sending bursts of serial clock. Each frame is 16 bits long: four zero bits come first, then the result from its most significant bit down to bit 0. The port has no select line. A host that shares the wire gates the serial clock instead. When the port is not sending, it releases the data line by deasserting an output enable, so the line can be three-stated.

The serial clock is asynchronous to the block. A two-flop synchroniser on a system clock that runs at least four times faster samples it, and a third flop turns the samples into rising and falling edge events. A load pulse from the conversion sequencer does three things:
- it captures the new result;
- it returns the frame pointer to the first bit;
- it releases the line.

A controller with four states walks through the frame:
- `ST_IDLE`: the line is released and the block waits for the first rising edge.
- `ST_DRIVE`: the line is driven with the current bit.
- `ST_HOLD`: a one-cycle hold that keeps the old bit on the line after a falling edge.
- `ST_PARK`: the line is released after a complete frame.

The controller makes these transitions:
- IDLE→DRIVE on a rising edge.
- DRIVE→HOLD on a falling edge.
- HOLD→DRIVE after advancing the pointer, or after wrapping it in restart mode.
- HOLD→PARK after the last bit when restart mode is off.
- PARK→DRIVE on a rising edge. This sets restart mode.
- Any state→IDLE on a load pulse.

Top module: `serial_result_port`

## Requirements
- R1: A frame is 16 bits: four zeros, then result bits 11 down to 0. Bit position k of the frame (k = 0 first) carries zero for k < 4 and result bit 15−k otherwise.
- R2: After reset, and after each load pulse, `sdo_en` is 0 until the first rising edge of `sclk`. That rising edge raises `sdo_en` and drives the first leading zero.
- R3: The frame position advances only on falling edges of `sclk`. Rising edges while a frame is being sent leave `sdo` unchanged.
- R4: After a falling edge is detected, the previous bit remains on `sdo` with `sdo_en` high for one `clk` cycle, and only then is the next bit presented.
- R5: The 16th falling edge presents no new bit. After the one-cycle hold, `sdo_en` goes to 0, and it stays 0 while `sclk` stays idle.
- R6: A rising edge that arrives after a complete frame restarts the frame at its first leading zero. From then on, the frame position wraps from the last bit back to the first. `sdo_en` stays 1, including after `sclk` stops, until the next load pulse.
- R7: A load pulse, even in the middle of a frame, returns the pointer to the first bit, sets `sdo_en` to 0 on the next cycle and clears restart mode.
- R8: The result is captured on the load pulse. Later changes on `result` do not alter the frame being sent.
- R9: An `sclk` transition that is set up before a `clk` rising edge takes effect on `sdo`/`sdo_en` after the third `clk` rising edge, counting that edge. A falling edge takes one cycle more because of the hold.
- R10: During reset, `sdo_en` and `sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for edge detection, at least 4× the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Externally supplied serial clock, asynchronous |
| result | input | 12 | Parallel conversion result |
| conv_start | input | 1 | One-cycle load pulse from the conversion sequencer |
| sdo | output | 1 | Serial data bit, 0 while released |
| sdo_en | output | 1 | Output enable for the data line; 0 means three-stated |

## Verification
The frame pointer and the controller state are visible at the ports only through `sdo` and `sdo_en`:
- A pointer that is off by one shows as a wrong bit at the next driven position, that is, within one serial-clock period.
- A lost restart flag shows as `sdo_en` falling after the 16th falling edge of the second frame.
- A wrong hold state shows as the data changing one system cycle early.

The reference model therefore checks both the value at each settled point and the intermediate hold cycle. It also checks that rising edges inside a frame leave the line unchanged, and that a load in the middle of a frame releases the line at once.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_HOLD  = 2'd2,
        ST_PARK  = 2'd3
    } srp_state_e;

endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_evt,
    output logic fall_evt
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_evt =  sync_q[STAGES-1] & ~prev_q;
    assign fall_evt = ~sync_q[STAGES-1] &  prev_q;

endmodule

// File: rtl/frame_store.sv
module frame_store #(
    parameter int DATA_W = 12,
    parameter int LEAD_W = 4,
    localparam int FRAME_W = DATA_W + LEAD_W,
    localparam int IDX_W = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic [IDX_W-1:0]  idx,
    output logic              bit_out
);

    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    frame_q <= '0;
        else if (load) frame_q <= {{LEAD_W{1'b0}}, data_in};
    end

    // position 0 is the most significant bit of the frame
    assign bit_out = frame_q[FRAME_W-1-int'(idx)];

endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl
    import srp_pkg::*;
#(
    parameter int FRAME_W = 16,
    localparam int IDX_W = $clog2(FRAME_W),
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             rise_evt,
    input  logic             fall_evt,
    output logic [IDX_W-1:0] idx,
    output logic             drive_en
);

    srp_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             wrap_q, wrap_d;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        wrap_d  = wrap_q;
        if (restart) begin
            state_d = ST_IDLE;
            idx_d   = '0;
            wrap_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (rise_evt) begin
                    state_d = ST_DRIVE;
                    idx_d   = '0;
                end
                ST_DRIVE: if (fall_evt) state_d = ST_HOLD;
                ST_HOLD: begin
                    if (idx_q == LAST_IDX) begin
                        if (wrap_q) begin
                            state_d = ST_DRIVE;
                            idx_d   = '0;
                        end else begin
                            state_d = ST_PARK;
                        end
                    end else begin
                        state_d = ST_DRIVE;
                        idx_d   = idx_q + 1'b1;
                    end
                end
                ST_PARK: if (rise_evt) begin
                    state_d = ST_DRIVE;
                    idx_d   = '0;
                    wrap_d  = 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            wrap_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            wrap_q  <= wrap_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_DRIVE, ST_HOLD: drive_en = 1'b1;
            default:           drive_en = 1'b0;
        endcase
        idx = idx_q;
    end

endmodule

// File: rtl/serial_result_port.sv
module serial_result_port #(
    parameter int DATA_W      = 12,
    parameter int LEAD_W      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int FRAME_W = DATA_W + LEAD_W,
    localparam int IDX_W = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] result,
    input  logic              conv_start,
    output logic              sdo,
    output logic              sdo_en
);

    logic             rise_evt;
    logic             fall_evt;
    logic [IDX_W-1:0] bit_idx;
    logic             frame_bit;
    logic             drive_en;

    sclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    shift_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (conv_start),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .idx      (bit_idx),
        .drive_en (drive_en)
    );

    frame_store #(.DATA_W(DATA_W), .LEAD_W(LEAD_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (conv_start),
        .data_in (result),
        .idx     (bit_idx),
        .bit_out (frame_bit)
    );

    assign sdo_en = drive_en;
    assign sdo    = drive_en & frame_bit;

endmodule

// File: rtl/serial_result_port_chk.sv
module serial_result_port_chk #(
    parameter int LEAD_W = 4,
    parameter int IDX_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_start,
    input logic             sdo,
    input logic             sdo_en,
    input logic             rise_evt,
    input logic             fall_evt,
    input logic [IDX_W-1:0] bit_idx
);

    // R7: load releases the line on the next cycle
    a_r7_load_releases: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !sdo_en);

    // R2: the line is only ever taken on a detected rising edge
    a_r2_enable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> $past(rise_evt));

    // R5: the line is released only after a load or two cycles after a falling edge
    a_r5_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_en) |-> ($past(conv_start) || $past(fall_evt, 2)));

    // R4: a driven bit changes only two cycles after a falling edge
    a_r4_change_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en && $past(sdo_en) && !$stable(sdo)) |-> $past(fall_evt, 2));

    // R1: leading positions carry zero
    a_r1_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en && (int'(bit_idx) < LEAD_W)) |-> !sdo);

    // R10: nothing is driven during reset
    always_comb begin
        if (!rst_n) a_r10_reset_quiet: assert (!sdo_en || $isunknown(sdo_en));
    end

endmodule

bind serial_result_port serial_result_port_chk #(.LEAD_W(LEAD_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .sdo        (sdo),
    .sdo_en     (sdo_en),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .bit_idx    (bit_idx)
);

// File: tb/serial_result_port_tb.sv
module serial_result_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic [11:0] result = '0;
    logic        conv_start = 1'b0;
    logic        sdo;
    logic        sdo_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural reference: 0 idle, 1 drive, 2 parked
    int          m_state = 0;
    int          m_idx   = 0;
    bit          m_wrap  = 0;
    logic [15:0] m_frame = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_result_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .result     (result),
        .conv_start (conv_start),
        .sdo        (sdo),
        .sdo_en     (sdo_en)
    );

    function automatic logic m_bit();
        return m_frame[15 - m_idx];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_port(input string req);
        chk({req, " en"}, sdo_en, logic'(m_state == 1));
        chk({req, " sdo"}, sdo, (m_state == 1) ? m_bit() : 1'b0);
    endtask

    task automatic do_load(input logic [11:0] v);
        @(negedge clk);
        result = v;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        m_frame = {4'b0000, v};
        m_state = 0; m_idx = 0; m_wrap = 0;
        chk_port("R7 load");
    endtask

    task automatic do_rise();
        int prev_state;
        logic prev_bit;
        prev_state = m_state;
        prev_bit = (m_state == 1) ? m_bit() : 1'b0;
        @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        if (prev_state != 1) chk("R9 rise not yet", sdo_en, 1'b0);
        @(negedge clk);
        if (prev_state != 1) begin
            if (prev_state == 2) m_wrap = 1;
            m_state = 1;
            m_idx = 0;
            chk_port("R2/R6 rise drives first zero");
        end else begin
            chk("R3 rise leaves data", sdo, prev_bit);
        end
        repeat (HALF_SCLK - 3) @(negedge clk);
        chk_port("R3 after rise");
    endtask

    task automatic do_fall();
        logic old_bit;
        @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
        if (m_state == 1) begin
            old_bit = m_bit();
            chk("R4 hold en", sdo_en, 1'b1);
            chk("R4 hold bit", sdo, old_bit);
            if (m_idx == 15) begin
                if (m_wrap) m_idx = 0;
                else        m_state = 2;
            end else begin
                m_idx++;
            end
        end
        @(negedge clk);
        chk_port("R1/R5/R9 after fall");
        repeat (HALF_SCLK - 4) @(negedge clk);
        chk_port("R5 settled");
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) begin
            do_rise();
            do_fall();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset en", sdo_en, 1'b0);
        chk("R10 reset sdo", sdo, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_port("R2 idle after reset");

        do_load(12'hA5C);
        repeat (8) @(negedge clk);
        chk_port("R2 idle before clock");
        // R8: change input after load
        result = 12'h3C3;
        clocks(16);
        repeat (10) @(negedge clk);
        chk_port("R5 parked");

        do_load(12'hFFF);
        clocks(16);
        do_load(12'h000);
        clocks(16);

        // R6: extra clocks restart and keep driving
        do_load(12'h801);
        clocks(16);
        clocks(20);
        repeat (20) @(negedge clk);
        chk("R6 stays driven", sdo_en, 1'b1);

        // R7: load mid-frame
        do_load(12'h5A6);
        clocks(7);
        do_load(12'h9E1);
        repeat (6) @(negedge clk);
        chk_port("R7 mid-frame reset");
        clocks(16);
        chk("R5 released after reload frame", sdo_en, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule